// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block sets the instruction-cycle timing of a small accumulator-based controller core. It splits the oscillator clock into instruction cycles of four phases, Q1 to Q4, and marks the last phase of every cycle with a strobe. From five class flags that the decoder presents, it decides whether the current instruction takes one, two or three instruction cycles. The five flags are call, return, branch, taken skip, and an indirect access whose pointer lands in program memory.

Call, return, branch and taken skip are the flow-change classes, and each one adds a second cycle. An indirect access into program memory adds one more cycle on top of that. The block drives four outputs:

- a pulse when the instruction finishes;
- a fetch enable that covers the instruction's final cycle;
- a flush flag during the second cycle of a flow change, so the core can drop the prefetched word and run it as a no-operation;
- the phase vector itself.

Decoding, program-counter arithmetic and memories sit outside the block.

The control is a three-state machine clocked at the end of each cycle. The states are:

- `ST_BASE` is the first cycle of every instruction.
- `ST_FLOW` is the second cycle of a flow change.
- `ST_EXTRA` is the added cycle for an indirect access into program memory.

The machine moves through these transitions at Q4:

- `ST_BASE -> ST_FLOW` when a flow class is set.
- `ST_BASE -> ST_EXTRA` when only the indirect class is set.
- `ST_BASE -> ST_BASE` for an ordinary instruction.
- `ST_FLOW -> ST_EXTRA` when the indirect class is also set.
- `ST_FLOW -> ST_BASE` otherwise.
- `ST_EXTRA -> ST_BASE` always.

Top module: `icyc_sequencer`

## Requirements
- R1: `phase` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It advances by one bit on every clock rising edge and wraps from Q4 to Q1. While reset is asserted and directly after release it shows Q1.
- R2: `cyc_end` is high exactly in the Q4 clock of every instruction cycle.
- R3: An instruction with no class flag set lasts 4 clocks, from one `exec_done` pulse to the next.
- R4: An instruction with any of call, return, branch or taken skip set, and the indirect class clear, lasts 8 clocks. This holds whether the flags are set alone or together.
- R5: The indirect-into-program-memory class adds 4 clocks. With no flow flag the instruction lasts 8 clocks; with any flow flag it lasts 12.
- R6: The class flags are taken in the Q1 clock of an instruction's first cycle. Changes to them in any later clock of that instruction do not change its length, fetch enable or flush.
- R7: `exec_done` is high for exactly one clock per instruction, in Q4 of the instruction's final cycle.
- R8: `fetch_en` is high in all four clocks of the final cycle and low in every earlier cycle of the instruction.
- R9: `flush` is high in all four clocks of the second cycle of a flow-change instruction, that is, clocks 5 to 8 of the instruction. It is low at all other times, including the indirect extra cycle and every cycle of an instruction without a flow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_call | input | 1 | Current instruction is a subroutine call |
| cls_ret | input | 1 | Current instruction is a return |
| cls_branch | input | 1 | Current instruction is a jump or branch |
| cls_skip | input | 1 | Current instruction is a skip whose condition holds |
| cls_ind_prog | input | 1 | Indirect access with pointer in program memory |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| cyc_end | output | 1 | Last phase of an instruction cycle |
| exec_done | output | 1 | Instruction completes this clock |
| fetch_en | output | 1 | Final cycle of the instruction |
| flush | output | 1 | Discard the prefetched word |

## Verification
The bench first runs each of the 32 combinations of the five class flags in a fixed order. For each one it measures the clock count between completion pulses and the clock positions of fetch and flush. These runs tell apart the 4, 8 and 12 clock lengths. They also separate flag sets that differ only by the indirect bit, and show whether the flush window falls in the flow cycle or in the extra cycle.

The bench then runs a long stretch of random class sequences. In these, the flags are scrambled in the second clock of each instruction. If the block resampled the flags after Q1, the length or the flush window would change and a check would catch it. The random sequences also cover back-to-back transitions between every pair of lengths.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    typedef enum logic [1:0] {
        ST_BASE  = 2'd0,
        ST_FLOW  = 2'd1,
        ST_EXTRA = 2'd2
    } icyc_state_t;

    typedef struct packed {
        logic call;
        logic ret;
        logic branch;
        logic skip;
        logic ind_prog;
    } icyc_class_t;

    function automatic logic class_is_flow(input icyc_class_t c);
        return c.call | c.ret | c.branch | c.skip;
    endfunction

endpackage

// File: rtl/icyc_phase_ring.sv
module icyc_phase_ring #(
    parameter int NUM_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase,
    output logic                  first_ph,
    output logic                  last_ph
);
    localparam int LAST = NUM_PHASES - 1;

    logic [NUM_PHASES-1:0] ring_q;
    logic [NUM_PHASES-1:0] ring_d;

    generate
        for (genvar i = 0; i < NUM_PHASES; i++) begin : g_rot
            if (i == 0) begin : g_wrap
                assign ring_d[i] = ring_q[LAST];
            end else begin : g_shift
                assign ring_d[i] = ring_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= {{(NUM_PHASES-1){1'b0}}, 1'b1};
        end else begin
            ring_q <= ring_d;
        end
    end

    assign phase    = ring_q;
    assign first_ph = ring_q[0];
    assign last_ph  = ring_q[LAST];
endmodule

// File: rtl/icyc_class_hold.sv
module icyc_class_hold
    import icyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_now,
    input  icyc_class_t live_cls,
    output logic        eff_flow,
    output logic        eff_ind
);
    icyc_class_t held_q;
    icyc_class_t eff_cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (sample_now) begin
            held_q <= live_cls;
        end
    end

    always_comb begin
        eff_cls  = sample_now ? live_cls : held_q;
        eff_flow = class_is_flow(eff_cls);
        eff_ind  = eff_cls.ind_prog;
    end
endmodule

// File: rtl/icyc_len_fsm.sv
module icyc_len_fsm
    import icyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_ph,
    input  logic last_ph,
    input  logic eff_flow,
    input  logic eff_ind,
    output logic sample_now,
    output logic exec_done,
    output logic fetch_en,
    output logic flush
);
    icyc_state_t state_q;
    icyc_state_t state_d;
    logic        final_cyc;

    always_comb begin
        state_d = state_q;
        if (last_ph) begin
            unique case (state_q)
                ST_BASE: begin
                    if (eff_flow)     state_d = ST_FLOW;
                    else if (eff_ind) state_d = ST_EXTRA;
                    else              state_d = ST_BASE;
                end
                ST_FLOW: begin
                    if (eff_ind) state_d = ST_EXTRA;
                    else         state_d = ST_BASE;
                end
                ST_EXTRA: state_d = ST_BASE;
                default:  state_d = ST_BASE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BASE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        final_cyc  = 1'b0;
        flush      = 1'b0;
        sample_now = 1'b0;
        unique case (state_q)
            ST_BASE: begin
                final_cyc  = !eff_flow && !eff_ind;
                sample_now = first_ph;
            end
            ST_FLOW: begin
                final_cyc = !eff_ind;
                flush     = 1'b1;
            end
            ST_EXTRA: final_cyc = 1'b1;
            default:  final_cyc = 1'b1;
        endcase
        fetch_en  = final_cyc;
        exec_done = final_cyc && last_ph;
    end
endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
    import icyc_pkg::*;
#(
    parameter int NUM_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cls_call,
    input  logic                  cls_ret,
    input  logic                  cls_branch,
    input  logic                  cls_skip,
    input  logic                  cls_ind_prog,
    output logic [NUM_PHASES-1:0] phase,
    output logic                  cyc_end,
    output logic                  exec_done,
    output logic                  fetch_en,
    output logic                  flush
);
    icyc_class_t live_cls;
    logic first_ph;
    logic last_ph;
    logic sample_now;
    logic eff_flow;
    logic eff_ind;

    assign live_cls = '{call: cls_call, ret: cls_ret, branch: cls_branch,
                        skip: cls_skip, ind_prog: cls_ind_prog};

    icyc_phase_ring #(.NUM_PHASES(NUM_PHASES)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .first_ph (first_ph),
        .last_ph  (last_ph)
    );

    icyc_class_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .live_cls   (live_cls),
        .eff_flow   (eff_flow),
        .eff_ind    (eff_ind)
    );

    icyc_len_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_ph   (first_ph),
        .last_ph    (last_ph),
        .eff_flow   (eff_flow),
        .eff_ind    (eff_ind),
        .sample_now (sample_now),
        .exec_done  (exec_done),
        .fetch_en   (fetch_en),
        .flush      (flush)
    );

    assign cyc_end = last_ph;
endmodule

// File: rtl/icyc_sequencer_chk.sv
module icyc_sequencer_chk #(
    parameter int NUM_PHASES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PHASES-1:0] phase,
    input logic                  cyc_end,
    input logic                  exec_done,
    input logic                  fetch_en,
    input logic                  flush
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        phase[NUM_PHASES-1] |=> phase[0]);

    a_r2_end_then_q1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (phase[0] && !cyc_end));

    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |-> (cyc_end && fetch_en));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> !exec_done);

    a_r8_fetch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(fetch_en)) |-> $past(exec_done));

    a_r9_flush_start: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(flush)) |-> phase[0]);
endmodule

bind icyc_sequencer icyc_sequencer_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cyc_end   (cyc_end),
    .exec_done (exec_done),
    .fetch_en  (fetch_en),
    .flush     (flush)
);

// File: tb/icyc_sequencer_tb.sv
module icyc_sequencer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] cls = 5'd0;   // {call, ret, branch, skip, ind_prog}
    logic [3:0] phase;
    logic cyc_end, exec_done, fetch_en, flush;
    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    icyc_sequencer u_dut (
        .clk (clk), .rst_n (rst_n),
        .cls_call (cls[4]), .cls_ret (cls[3]), .cls_branch (cls[2]),
        .cls_skip (cls[1]), .cls_ind_prog (cls[0]),
        .phase (phase), .cyc_end (cyc_end), .exec_done (exec_done),
        .fetch_en (fetch_en), .flush (flush)
    );

    function automatic bit is_flow(input logic [4:0] c);
        return |c[4:1];
    endfunction

    function automatic int exp_len(input logic [4:0] c);
        return 1 + int'(is_flow(c)) + int'(c[0]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (class %b)", req, act, exp, cls);
        end
    endtask

    task automatic run_instr(input logic [4:0] c, input bit at_q1, input bit scramble);
        int clocks, dones;
        bit flw;
        clocks = 4 * exp_len(c);
        flw = is_flow(c);
        dones = 0;
        cls = c;
        for (int k = 1; k <= clocks; k++) begin
            if (!(at_q1 && k == 1)) @(negedge clk);
            chk("R1 phase", int'(phase), 1 << ((k - 1) % 4));
            chk("R2 cyc_end", int'(cyc_end), int'(((k - 1) % 4) == 3));
            chk("R8 fetch_en", int'(fetch_en), int'(k > clocks - 4));
            chk("R9 flush", int'(flush), int'(flw && k >= 5 && k <= 8));
            if (k < clocks) begin
                if (exec_done) dones++;
            end
            if (k == 2 && scramble) cls = 5'($urandom);
        end
        if (!flw && !c[0]) chk("R3 length", int'(exec_done), 1);
        else if (!c[0])    chk("R4 length", int'(exec_done), 1);
        else               chk("R5 length", int'(exec_done), 1);
        chk("R7 early done", dones, 0);
        if (scramble) chk("R6 held class", int'(exec_done), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset phase", int'(phase), 1);
        rst_n = 1'b1;
        chk("R1 release phase", int'(phase), 1);
        run_instr(5'd0, 1'b1, 1'b0);
        for (int i = 0; i < 32; i++) run_instr(5'(i), 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) run_instr(5'($urandom), 1'b0, 1'b1);
        run_instr(5'b00001, 1'b0, 1'b1);
        run_instr(5'b10001, 1'b0, 1'b1);
        run_instr(5'b00010, 1'b0, 1'b1);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule